// File: doc/BRIEF.md
# Load/Store Alignment and Endian Unit

This block sits between a 32-bit processor core and a 32-bit data bus. For a store it places the byte, word or longword from the core onto the right byte lanes of the bus and drives the matching byte enables. For a load it picks the addressed byte or word out of the bus word and sign-extends it to 32 bits. It also checks alignment. A misaligned word or longword access, or an access with the reserved size code, is not issued to the bus. Instead it is reported back as an address error.

Byte order is taken from a strap input. The strap is sampled on every clock edge while reset is held low, and the value is frozen once reset is released. The bus is assumed to return read data in the same cycle as the request. The load result, the response strobe and the error flag are registered and appear one cycle after the request. A separate combinational helper widens an 8-bit immediate for the ALU. It sign-extends for arithmetic use and zero-extends for logical use.

Top module: `lsu_align_unit`

## Requirements
- R1: A byte access (size code 2'b00) at any address offset 0..3 raises no address error and issues a bus request.
- R2: A word access (size code 2'b01) at an odd address raises the address error. At offsets 0 and 2 it raises no error.
- R3: A longword access (size code 2'b10) with address bits [1:0] not equal to 2'b00 raises the address error.
- R4: Size code 2'b11 raises the address error at every offset.
- R5: On an errored access, bus_req_o and all of bus_be_o are low in the request cycle. In the next cycle rsp_valid_o and rsp_addr_err_o are high for exactly one cycle and rsp_rdata_o is zero. Every accepted request gets rsp_valid_o one cycle later.
- R6: While rst_ni is low, endian_strap_i is sampled on each clock edge (0 = big endian, 1 = little endian). After reset is released, changes on the strap have no effect.
- R7: In big-endian mode, the byte at offset n uses lane 3-n, and the word at offset 0 uses lanes 3:2. Byte enable bit k covers bus bits 8k+7:8k.
- R8: In little-endian mode, the byte at offset n uses lane n, and the word at offset 0 uses lanes 1:0.
- R9: For a store, the source byte is copied to all four lanes of bus_wdata_o, and the source word is copied to both halves. A longword passes unchanged. Only the selected lanes' byte enables are set: one for a byte, two for a word, four for a longword.
- R10: For a load, the selected byte or word is sign-extended to 32 bits and a longword is returned unchanged, on rsp_rdata_o one cycle after the request. A store returns zero.
- R11: imm_ext_o is imm_i sign-extended when imm_logical_i is 0, and zero-extended when it is 1. It is combinational.
- R12: bus_addr_o equals req_addr_i with bits [1:0] cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; the strap is sampled while it is low |
| endian_strap_i | input | 1 | Byte-order strap: 0 big endian, 1 little endian |
| req_valid_i | input | 1 | Access request from the core |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | 00 byte, 01 word, 10 longword, 11 reserved |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store data, right-aligned |
| bus_req_o | output | 1 | Bus access strobe |
| bus_we_o | output | 1 | Bus write |
| bus_addr_o | output | 32 | Word-aligned bus address |
| bus_be_o | output | 4 | Byte enables, bit k for bits 8k+7:8k |
| bus_wdata_o | output | 32 | Lane-placed store data |
| bus_rdata_i | input | 32 | Bus read data, valid in the request cycle |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata_o | output | 32 | Extended load result |
| rsp_addr_err_o | output | 1 | Address error for the responded access |
| imm_i | input | 8 | Immediate operand |
| imm_logical_i | input | 1 | 1 = zero-extend, 0 = sign-extend |
| imm_ext_o | output | 32 | Widened immediate |

## Verification
The hardest situation to reach from the ports is a strap that changes after reset has been released. The mode register cannot be read directly. Its value only shows up in which lanes an access selects. The bench therefore resets the block with the strap at one level, flips the strap during normal operation, and issues byte and word loads and stores. These must still follow the lane mapping of the captured mode. A full sweep over size, offset and direction is run once in each mode. The sweep is repeated with two read patterns so that both positive and negative bytes and words pass through the sign extension.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
  import lsu_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             err_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: err_o = 1'b0;
      SZ_WORD: err_o = off_i[0];
      SZ_LONG: err_o = |off_i;
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
  import lsu_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int OFF_W     = $clog2(NUM_LANES)
) (
  input  acc_size_e              size_i,
  input  logic [OFF_W-1:0]       off_i,
  input  logic                   little_i,
  output logic [NUM_LANES-1:0]   be_o,
  output logic [OFF_W-1:0]       byte_lane_o,
  output logic                   half_sel_o
);
  // big endian mirrors the offset inside the word
  assign byte_lane_o = little_i ? off_i : ~off_i;
  assign half_sel_o  = off_i[OFF_W-1] ^ ~little_i;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE = OFF_W'(k);
    always_comb begin
      unique case (size_i)
        SZ_BYTE: be_o[k] = (byte_lane_o == LANE);
        SZ_WORD: be_o[k] = (LANE[OFF_W-1] == half_sel_o);
        SZ_LONG: be_o[k] = 1'b1;
        default: be_o[k] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e         size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int NUM_LANES = DATA_W / 8;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[8*k +: 8] = wdata_i[7:0];
        SZ_WORD: wdata_o[8*k +: 8] = wdata_i[8*(k%2) +: 8];
        default: wdata_o[8*k +: 8] = wdata_i[8*k +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2
) (
  input  acc_size_e         size_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [OFF_W-1:0]  byte_lane_i,
  input  logic              half_sel_i,
  output logic [DATA_W-1:0] data_o
);
  logic [7:0]  sel_byte;
  logic [15:0] sel_half;

  assign sel_byte = rdata_i[{byte_lane_i, 3'b000} +: 8];
  assign sel_half = rdata_i[{half_sel_i, 4'b0000} +: 16];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-8){sel_byte[7]}}, sel_byte};
      SZ_WORD: data_o = {{(DATA_W-16){sel_half[15]}}, sel_half};
      SZ_LONG: data_o = rdata_i;
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/lsu_imm_ext.sv
module lsu_imm_ext #(
  parameter int IMM_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              logical_i,
  output logic [DATA_W-1:0] imm_o
);
  logic fill;
  assign fill  = imm_i[IMM_W-1] & ~logical_i;
  assign imm_o = {{(DATA_W-IMM_W){fill}}, imm_i};
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              endian_strap_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W/8-1:0] bus_be_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_addr_err_o,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              imm_logical_i,
  output logic [DATA_W-1:0] imm_ext_o
);
  localparam int NUM_LANES = DATA_W / 8;
  localparam int OFF_W     = $clog2(NUM_LANES);

  acc_size_e              size;
  logic [OFF_W-1:0]       off;
  logic                   little_q;
  logic                   err;
  logic [NUM_LANES-1:0]   lane_be;
  logic [OFF_W-1:0]       byte_lane;
  logic                   half_sel;
  logic [DATA_W-1:0]      load_ext;
  logic                   rsp_valid_q;
  logic                   rsp_err_q;
  logic [DATA_W-1:0]      rsp_data_q;

  assign size = acc_size_e'(req_size_i);
  assign off  = req_addr_i[OFF_W-1:0];

  // strap follows while reset is held, frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) little_q <= endian_strap_i;
  end

  lsu_align_chk #(.OFF_W(OFF_W)) u_align (
    .size_i (size),
    .off_i  (off),
    .err_o  (err)
  );

  lsu_lane_map #(.NUM_LANES(NUM_LANES), .OFF_W(OFF_W)) u_lanes (
    .size_i      (size),
    .off_i       (off),
    .little_i    (little_q),
    .be_o        (lane_be),
    .byte_lane_o (byte_lane),
    .half_sel_o  (half_sel)
  );

  lsu_store_path #(.DATA_W(DATA_W)) u_store (
    .size_i  (size),
    .wdata_i (req_wdata_i),
    .wdata_o (bus_wdata_o)
  );

  lsu_load_extract #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_load (
    .size_i      (size),
    .rdata_i     (bus_rdata_i),
    .byte_lane_i (byte_lane),
    .half_sel_i  (half_sel),
    .data_o      (load_ext)
  );

  lsu_imm_ext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_imm (
    .imm_i     (imm_i),
    .logical_i (imm_logical_i),
    .imm_o     (imm_ext_o)
  );

  assign bus_req_o  = req_valid_i & ~err;
  assign bus_we_o   = req_we_i;
  assign bus_addr_o = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign bus_be_o   = bus_req_o ? lane_be : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_err_q   <= req_valid_i & err;
      rsp_data_q  <= (req_valid_i && !err && !req_we_i) ? load_ext : '0;
    end
  end

  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_addr_err_o = rsp_err_q;
  assign rsp_rdata_o    = rsp_data_q;
endmodule

// File: rtl/lsu_align_unit_chk.sv
module lsu_align_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        little_q,
  input logic        req_valid_i,
  input logic        req_we_i,
  input logic [1:0]  req_size_i,
  input logic [31:0] req_addr_i,
  input logic        bus_req_o,
  input logic [31:0] bus_addr_o,
  input logic [3:0]  bus_be_o,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_rdata_o,
  input logic        rsp_addr_err_o
);
  // R1
  a_r1_byte_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == 2'b00) |=> !rsp_addr_err_o);
  // R4
  a_r4_bad_size_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == 2'b11) |-> (!bus_req_o && bus_be_o == 4'h0));
  // R5
  a_r5_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r5_err_no_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o |-> bus_be_o == 4'h0);
  a_r5_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_addr_err_o |-> (rsp_valid_o && rsp_rdata_o == 32'h0));
  // R6
  a_r6_mode_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(little_q));
  // R9
  a_r9_byte_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && req_size_i == 2'b00) |-> $countones(bus_be_o) == 1);
  a_r9_word_two_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && req_size_i == 2'b01) |-> (bus_be_o == 4'h3 || bus_be_o == 4'hC));
  // R10
  a_r10_byte_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i && req_size_i == 2'b00) |=>
      rsp_rdata_o[31:8] == {24{rsp_rdata_o[7]}});
  // R12
  a_r12_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_addr_o[1:0] == 2'b00 && bus_addr_o[31:2] == req_addr_i[31:2]));
endmodule

bind lsu_align_unit lsu_align_unit_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .little_q       (little_q),
  .req_valid_i    (req_valid_i),
  .req_we_i       (req_we_i),
  .req_size_i     (req_size_i),
  .req_addr_i     (req_addr_i),
  .bus_req_o      (bus_req_o),
  .bus_addr_o     (bus_addr_o),
  .bus_be_o       (bus_be_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_rdata_o    (rsp_rdata_o),
  .rsp_addr_err_o (rsp_addr_err_o)
);

// File: tb/lsu_align_unit_tb.sv
module lsu_align_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [7:0]  imm = '0;
  logic        imm_logical = 1'b0;
  logic [31:0] imm_ext;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lsu_align_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .endian_strap_i(strap),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_be_o(bus_be), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_addr_err_o(rsp_err),
    .imm_i(imm), .imm_logical_i(imm_logical), .imm_ext_o(imm_ext)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic mode);
    rst_ni = 1'b0;
    strap  = mode;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // reference: lane number of the byte at a given offset
  function automatic int ref_lane(logic le, int o);
    return le ? o : 3 - o;
  endfunction

  // one access; returns comb outputs in the request cycle and response next cycle
  task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [31:0] rd,
                        output logic req_o, output logic [3:0] be_o,
                        output logic [31:0] wdo, output logic [31:0] ado,
                        output logic rv, output logic er, output logic [31:0] rdo);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_size = sz; req_addr = addr;
    req_wdata = wd; bus_rdata = rd;
    #1;
    req_o = bus_req; be_o = bus_be; wdo = bus_wdata; ado = bus_addr;
    @(negedge clk);
    rv = rsp_valid; er = rsp_err; rdo = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    chk("R5 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R5 reset err", {31'b0, rsp_err}, 32'h0);
    chk("R5 idle bus_req", {31'b0, bus_req}, 32'h0);
    chk("R5 reset rdata", rsp_rdata, 32'h0);
  endtask

  task automatic t_sweep(logic le, logic [31:0] rd);
    logic r; logic [3:0] b; logic [31:0] w, a, d; logic v, e;
    string mtag;
    mtag = le ? "R8" : "R7";
    for (int sz = 0; sz < 3; sz++) begin
      for (int o = 0; o < 4; o++) begin
        for (int we = 0; we < 2; we++) begin
          logic exp_err;
          logic [3:0] exp_be;
          logic [31:0] exp_wd, exp_rd, wd_in, addr;
          int base;
          wd_in = 32'hA5C3_96F1 ^ {o[7:0], 24'h0};
          addr  = 32'h0000_1230 + o;
          exp_err = (sz == 1 && o[0]) || (sz == 2 && o != 0);
          base = le ? (o & 2) : (2 - (o & 2));
          case (sz)
            0: begin
              exp_be = 4'b0001 << ref_lane(le, o);
              exp_wd = {4{wd_in[7:0]}};
              exp_rd = {{24{rd[8*ref_lane(le, o)+7]}}, rd[8*ref_lane(le, o) +: 8]};
            end
            1: begin
              exp_be = 4'b0011 << base;
              exp_wd = {2{wd_in[15:0]}};
              exp_rd = {{16{rd[8*base+15]}}, rd[8*base +: 16]};
            end
            default: begin
              exp_be = 4'hF;
              exp_wd = wd_in;
              exp_rd = rd;
            end
          endcase
          if (exp_err) begin exp_be = 4'h0; exp_rd = 32'h0; end
          if (we == 1) exp_rd = 32'h0;
          access(we[0], sz[1:0], addr, wd_in, rd, r, b, w, a, v, e, d);
          chk(sz == 0 ? "R1 byte err" : (sz == 1 ? "R2 word err" : "R3 long err"),
              {31'b0, e}, {31'b0, exp_err});
          chk({mtag, " be"}, {28'b0, b}, {28'b0, exp_be});
          chk("R5 bus_req", {31'b0, r}, {31'b0, ~exp_err});
          chk("R5 rsp_valid", {31'b0, v}, 32'h1);
          if (!exp_err) chk("R12 bus_addr", a, 32'h0000_1230);
          if (we == 1 && !exp_err) chk("R9 store data", w, exp_wd);
          if (we == 0) chk({mtag, " R10 load data"}, d, exp_rd);
        end
      end
    end
  endtask

  task automatic t_bad_size();
    logic r; logic [3:0] b; logic [31:0] w, a, d; logic v, e;
    for (int o = 0; o < 4; o++) begin
      access(1'b0, 2'b11, 32'h40 + o, 32'h0, 32'hFFFF_FFFF, r, b, w, a, v, e, d);
      chk("R4 bad size err", {31'b0, e}, 32'h1);
      chk("R4 bad size be", {28'b0, b}, 32'h0);
      chk("R5 err rdata zero", d, 32'h0);
    end
    // error flag lasts one cycle
    @(negedge clk);
    chk("R5 err one cycle", {30'b0, rsp_valid, rsp_err}, 32'h0);
  endtask

  task automatic t_strap_change();
    logic r; logic [3:0] b; logic [31:0] w, a, d; logic v, e;
    do_reset(1'b1);
    strap = 1'b0;
    repeat (2) @(negedge clk);
    access(1'b0, 2'b00, 32'h1, 32'h0, 32'h0011_8000, r, b, w, a, v, e, d);
    chk("R6 strap ignored be", {28'b0, b}, 32'h2);
    chk("R6 strap ignored data", d, 32'hFFFF_FF80);
    access(1'b1, 2'b01, 32'h2, 32'h0000_1234, 32'h0, r, b, w, a, v, e, d);
    chk("R6 strap ignored word be", {28'b0, b}, 32'hC);
    strap = 1'b1;
    do_reset(1'b0);
    strap = 1'b1;
    access(1'b0, 2'b00, 32'h1, 32'h0, 32'h0011_8000, r, b, w, a, v, e, d);
    chk("R6 big after reset be", {28'b0, b}, 32'h4);
    chk("R6 big after reset data", d, 32'h0000_0011);
  endtask

  task automatic t_imm();
    imm = 8'h80; imm_logical = 1'b0; #1;
    chk("R11 sext neg", imm_ext, 32'hFFFF_FF80);
    imm_logical = 1'b1; #1;
    chk("R11 zext neg", imm_ext, 32'h0000_0080);
    imm = 8'h7F; imm_logical = 1'b0; #1;
    chk("R11 sext pos", imm_ext, 32'h0000_007F);
  endtask

  initial begin
    t_reset_state();
    t_imm();
    t_sweep(1'b0, 32'h817E_C335);
    t_sweep(1'b0, 32'h017E_4335);
    t_bad_size();
    do_reset(1'b1);
    t_sweep(1'b1, 32'h817E_C335);
    t_sweep(1'b1, 32'h017E_4335);
    t_strap_change();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule